// File: doc/BRIEF.md
# Block and Byte Transfer Counter

This block sits between a 16-bit host FIFO and a byte-wide card data port and moves a programmed amount of data between them. Software (or a sequencer) sets a block length in bytes and a number of blocks, then starts a transfer in one of two directions. In the card-to-FIFO direction the block fetches card bytes two at a time and pushes each pair into the FIFO as one word. In the FIFO-to-card direction it takes words from the head of the FIFO and sends their two bytes to the card one after the other.

A byte counter counts down inside each block and a block counter counts down across the transfer. At every block boundary the byte counter reloads, so an odd block length ends each block with a half-filled word. When the last byte of the last block moves, both counters reload, the transfer stops and a one-cycle completion pulse is raised. Card-to-FIFO traffic holds off while the FIFO holds more words than a programmable threshold; FIFO-to-card traffic holds off while the FIFO is empty. The two live down-counters are always visible on output ports.

Top module: `blk_xfer_ctr`

## Requirements
- R1: After reset both live counters read 0, no transfer is active, no card request, FIFO push, FIFO pop or completion pulse is raised.
- R2: A write to the length field stores a block length equal to the field value plus 1 and loads the live byte counter with that length on the next cycle.
- R3: A write to the count field stores a block count equal to the field value plus 1, loads the live block counter with it, and reloads the live byte counter from the stored length.
- R4: In the card-to-FIFO direction (start direction 1) the first card byte of a word lands in bits 7:0 and the second in bits 15:8; when a block's byte count runs out after the first byte, the word is pushed with bits 15:8 equal to 0 and no second byte is requested.
- R5: In the FIFO-to-card direction (start direction 0) bits 7:0 of the head word go to the card first and bits 15:8 second; when a block's byte count runs out after the first byte, the word is popped without sending its upper byte.
- R6: In the card-to-FIFO direction, no new word is begun while the FIFO count is above the almost-full threshold; the card read request stays low until the count drops to the threshold or below.
- R7: In the FIFO-to-card direction, no card write request is raised while the FIFO count is 0.
- R8: Each byte that moves lowers the live byte counter by 1; when it reaches the end of a block the byte counter reloads to the block length and the block counter drops by 1.
- R9: After the last byte of the last block the block counter reloads to the block count, the byte counter to the block length, the transfer ends with no further card requests, and the completion output is high for exactly the one following cycle.
- R10: A start request while a transfer is active is ignored; in particular its direction does not take effect.
- R11: A card byte moves only in a cycle where its request and acknowledge are both high, and at most one card byte moves per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lenWrEn | input | 1 | Write strobe for the block length field |
| lenWrVal | input | LEN_FIELD_W | Block length minus 1 |
| cntWrEn | input | 1 | Write strobe for the block count field |
| cntWrVal | input | LEN_FIELD_W | Block count minus 1 |
| startEn | input | 1 | Begin a transfer (ignored while busy) |
| startDir | input | 1 | 1: card to FIFO, 0: FIFO to card |
| afLevel | input | LVL_W | Almost-full threshold for card-to-FIFO traffic |
| fifoCount | input | LVL_W | Words currently held in the FIFO |
| fifoPushValid | output | 1 | Push fifoPushData into the FIFO this cycle |
| fifoPushData | output | 16 | Assembled word |
| fifoPopReady | output | 1 | Remove the FIFO head word this cycle |
| fifoPopData | input | 16 | FIFO head word |
| cardRdReq | output | 1 | Request a byte from the card |
| cardRdAck | input | 1 | Card supplies cardRdData this cycle |
| cardRdData | input | 8 | Byte from the card |
| cardWrReq | output | 1 | Offer cardWrData to the card |
| cardWrAck | input | 1 | Card takes cardWrData this cycle |
| cardWrData | output | 8 | Byte to the card |
| lenLive | output | LEN_FIELD_W+1 | Live byte down-counter |
| cntLive | output | LEN_FIELD_W+1 | Live block down-counter |
| busy | output | 1 | A transfer is in progress |
| doneStb | output | 1 | One-cycle pulse after the final byte |

## Verification
The bench builds the block with a 4-bit length field and an 8-word FIFO, which keeps every block length from 1 to 9 and every block count from 1 to 3 cheap enough to sweep in both directions, with odd and even lengths exercising the half-word ending at each boundary. Byte values are a known arithmetic sequence, so every pushed word and every sent byte is predicted from its block and word index. A lowered threshold and a starved FIFO bring the two pause conditions within reach, and a held-off acknowledge lets the live counters, a mid-transfer count rewrite and an ignored start be observed one byte at a time.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // Phase of the current word in each direction.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_WR_LO,
    ST_WR_HI
  } xfer_state_e;

  // Control to datapath strobes.
  typedef struct packed {
    logic stepByte;   // one card byte moves this cycle
    logic upperHalf;  // the moving byte is the upper half of a word
    logic readDir;    // card to FIFO
  } xfer_strobe_t;

  // Datapath to control flags.
  typedef struct packed {
    logic lastByte;   // byte counter is on the last byte of a block
    logic lastBlock;  // block counter is on the last block
  } xfer_flags_t;

endpackage

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
  import blk_xfer_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startEn,
  input  logic               startDir,
  input  logic [LVL_W-1:0]   afLevel,
  input  logic [LVL_W-1:0]   fifoCount,
  input  logic               cardRdAck,
  input  logic               cardWrAck,
  input  xfer_flags_t        flags,
  output logic               cardRdReq,
  output logic               cardWrReq,
  output logic               fifoPushValid,
  output logic               fifoPopReady,
  output xfer_strobe_t       strobe,
  output logic               busy,
  output logic               doneStb,
  output logic               inHiPhase
);

  xfer_state_e state, stNext;

  logic rdLo, rdHi, wrLo, wrHi;
  logic readDir, moveByte, wordEnd, xferEnd;

  always_comb begin
    rdLo = (state == ST_RD_LO);
    rdHi = (state == ST_RD_HI);
    wrLo = (state == ST_WR_LO);
    wrHi = (state == ST_WR_HI);
    readDir   = rdLo || rdHi;
    inHiPhase = rdHi || wrHi;

    // A new word only begins when the FIFO allows it; the second half of a
    // word always follows, since the word was admitted as a whole.
    cardRdReq = (rdLo && (fifoCount <= afLevel)) || rdHi;
    cardWrReq = (wrLo && (fifoCount != '0)) || wrHi;

    moveByte = (cardRdReq && cardRdAck) || (cardWrReq && cardWrAck);
    wordEnd  = moveByte && (inHiPhase || flags.lastByte);
    xferEnd  = moveByte && flags.lastByte && flags.lastBlock;

    fifoPushValid = wordEnd && readDir;
    fifoPopReady  = wordEnd && !readDir && (wrLo || wrHi);

    strobe.stepByte  = moveByte;
    strobe.upperHalf = inHiPhase;
    strobe.readDir   = readDir;

    busy = (state != ST_IDLE);
  end

  always_comb begin
    stNext = state;
    case (state)
      ST_IDLE: begin
        if (startEn) stNext = startDir ? ST_RD_LO : ST_WR_LO;
      end
      default: begin
        if (xferEnd)       stNext = ST_IDLE;
        else if (wordEnd)  stNext = readDir ? ST_RD_LO : ST_WR_LO;
        else if (moveByte) stNext = readDir ? ST_RD_HI : ST_WR_HI;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneStb <= 1'b0;
    end else begin
      state   <= stNext;
      doneStb <= xferEnd;
    end
  end

endmodule

// File: rtl/blk_xfer_dp.sv
module blk_xfer_dp
  import blk_xfer_pkg::*;
#(
  parameter int LEN_FIELD_W = 11,
  parameter int CNT_W       = LEN_FIELD_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lenWrEn,
  input  logic [LEN_FIELD_W-1:0] lenWrVal,
  input  logic                   cntWrEn,
  input  logic [LEN_FIELD_W-1:0] cntWrVal,
  input  xfer_strobe_t           strobe,
  input  logic [BYTE_W-1:0]      cardRdData,
  input  logic [WORD_W-1:0]      fifoPopData,
  output logic [WORD_W-1:0]      fifoPushData,
  output logic [BYTE_W-1:0]      cardWrData,
  output logic [CNT_W-1:0]       lenLive,
  output logic [CNT_W-1:0]       cntLive,
  output xfer_flags_t            flags
);

  logic [CNT_W-1:0]  blkLen, blkNum, byteCnt, blkCnt;
  logic [CNT_W-1:0]  lenNew, numNew, lenReload;
  logic [BYTE_W-1:0] lowByte;

  always_comb begin
    lenNew    = CNT_W'({1'b0, lenWrVal}) + CNT_W'(1);
    numNew    = CNT_W'({1'b0, cntWrVal}) + CNT_W'(1);
    lenReload = lenWrEn ? lenNew : blkLen;
    flags.lastByte  = (byteCnt == CNT_W'(1));
    flags.lastBlock = (blkCnt == CNT_W'(1));
    lenLive = byteCnt;
    cntLive = blkCnt;
  end

  // Byte lanes of the word: lane 0 carries the first byte, lane 1 the second.
  logic [BYTE_W-1:0] popLane [2];
  logic [BYTE_W-1:0] pushLane[2];

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    assign popLane[lane] = fifoPopData[lane*BYTE_W +: BYTE_W];
    assign fifoPushData[lane*BYTE_W +: BYTE_W] = pushLane[lane];
  end

  always_comb begin
    cardWrData = strobe.upperHalf ? popLane[1] : popLane[0];
    if (strobe.upperHalf) begin
      pushLane[0] = lowByte;
      pushLane[1] = cardRdData;
    end else begin
      // a word closed after its first byte carries zero in its upper lane
      pushLane[0] = cardRdData;
      pushLane[1] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowByte <= '0;
    end else if (strobe.stepByte && strobe.readDir && !strobe.upperHalf) begin
      lowByte <= cardRdData;
    end
  end

  // Register writes take priority over counting in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkLen  <= '0;
      blkNum  <= '0;
      byteCnt <= '0;
      blkCnt  <= '0;
    end else begin
      if (lenWrEn) blkLen <= lenNew;
      if (cntWrEn) blkNum <= numNew;

      if (cntWrEn) begin
        blkCnt  <= numNew;
        byteCnt <= lenReload;
      end else if (lenWrEn) begin
        byteCnt <= lenNew;
      end else if (strobe.stepByte) begin
        if (flags.lastByte) begin
          byteCnt <= blkLen;
          blkCnt  <= flags.lastBlock ? blkNum : blkCnt - CNT_W'(1);
        end else begin
          byteCnt <= byteCnt - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/blk_xfer_ctr.sv
module blk_xfer_ctr
  import blk_xfer_pkg::*;
#(
  parameter  int LEN_FIELD_W = 11,
  parameter  int FIFO_DEPTH  = 32,
  localparam int CNT_W       = LEN_FIELD_W + 1,
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lenWrEn,
  input  logic [LEN_FIELD_W-1:0] lenWrVal,
  input  logic                   cntWrEn,
  input  logic [LEN_FIELD_W-1:0] cntWrVal,
  input  logic                   startEn,
  input  logic                   startDir,
  input  logic [LVL_W-1:0]       afLevel,
  input  logic [LVL_W-1:0]       fifoCount,
  output logic                   fifoPushValid,
  output logic [15:0]            fifoPushData,
  output logic                   fifoPopReady,
  input  logic [15:0]            fifoPopData,
  output logic                   cardRdReq,
  input  logic                   cardRdAck,
  input  logic [7:0]             cardRdData,
  output logic                   cardWrReq,
  input  logic                   cardWrAck,
  output logic [7:0]             cardWrData,
  output logic [CNT_W-1:0]       lenLive,
  output logic [CNT_W-1:0]       cntLive,
  output logic                   busy,
  output logic                   doneStb
);

  xfer_strobe_t strobe;
  xfer_flags_t  flags;
  logic         inHiPhase;

  blk_xfer_ctrl #(.LVL_W(LVL_W)) ctrlU (
    .clk           (clk),
    .rstN          (rstN),
    .startEn       (startEn),
    .startDir      (startDir),
    .afLevel       (afLevel),
    .fifoCount     (fifoCount),
    .cardRdAck     (cardRdAck),
    .cardWrAck     (cardWrAck),
    .flags         (flags),
    .cardRdReq     (cardRdReq),
    .cardWrReq     (cardWrReq),
    .fifoPushValid (fifoPushValid),
    .fifoPopReady  (fifoPopReady),
    .strobe        (strobe),
    .busy          (busy),
    .doneStb       (doneStb),
    .inHiPhase     (inHiPhase)
  );

  blk_xfer_dp #(.LEN_FIELD_W(LEN_FIELD_W), .CNT_W(CNT_W)) dpU (
    .clk          (clk),
    .rstN         (rstN),
    .lenWrEn      (lenWrEn),
    .lenWrVal     (lenWrVal),
    .cntWrEn      (cntWrEn),
    .cntWrVal     (cntWrVal),
    .strobe       (strobe),
    .cardRdData   (cardRdData),
    .fifoPopData  (fifoPopData),
    .fifoPushData (fifoPushData),
    .cardWrData   (cardWrData),
    .lenLive      (lenLive),
    .cntLive      (cntLive),
    .flags        (flags)
  );

endmodule

// File: rtl/blk_xfer_ctr_chk.sv
module blk_xfer_ctr_chk #(
  parameter int LVL_W = 6,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             cardRdReq,
  input logic             cardRdAck,
  input logic             cardWrReq,
  input logic             cardWrAck,
  input logic             fifoPushValid,
  input logic             fifoPopReady,
  input logic [LVL_W-1:0] fifoCount,
  input logic [LVL_W-1:0] afLevel,
  input logic [CNT_W-1:0] lenLive,
  input logic             lenWrEn,
  input logic             cntWrEn,
  input logic             busy,
  input logic             doneStb,
  input logic             inHiPhase
);

  logic stepByte;
  assign stepByte = (cardRdReq && cardRdAck) || (cardWrReq && cardWrAck);

  // R11
  one_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cardRdReq, cardWrReq}));

  // R4
  push_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPushValid |-> (cardRdReq && cardRdAck));

  // R5
  pop_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPopReady |-> (cardWrReq && cardWrAck));

  // R6
  af_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardRdReq && (fifoCount > afLevel)) |-> inHiPhase);

  // R7
  empty_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardWrReq |-> (fifoCount != '0));

  // R8
  byte_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepByte && (lenLive > CNT_W'(1)) && !lenWrEn && !cntWrEn)
      |=> (lenLive == $past(lenLive) - CNT_W'(1)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (!busy && !cardRdReq && !cardWrReq));

  // R9
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> $past(stepByte));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

endmodule

bind blk_xfer_ctr blk_xfer_ctr_chk #(.LVL_W(LVL_W), .CNT_W(CNT_W)) chkU (
  .clk           (clk),
  .rstN          (rstN),
  .cardRdReq     (cardRdReq),
  .cardRdAck     (cardRdAck),
  .cardWrReq     (cardWrReq),
  .cardWrAck     (cardWrAck),
  .fifoPushValid (fifoPushValid),
  .fifoPopReady  (fifoPopReady),
  .fifoCount     (fifoCount),
  .afLevel       (afLevel),
  .lenLive       (lenLive),
  .lenWrEn       (lenWrEn),
  .cntWrEn       (cntWrEn),
  .busy          (busy),
  .doneStb       (doneStb),
  .inHiPhase     (inHiPhase)
);

// File: tb/tb_blk_xfer_ctr.sv
`timescale 1ns/1ps
module tb_blk_xfer_ctr;

  localparam int LEN_FIELD_W = 4;
  localparam int FIFO_DEPTH  = 8;
  localparam int CNT_W       = LEN_FIELD_W + 1;
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic                   lenWrEn = 0, cntWrEn = 0, startEn = 0, startDir = 0;
  logic [LEN_FIELD_W-1:0] lenWrVal = '0, cntWrVal = '0;
  logic [LVL_W-1:0]       afLevel = '1;
  logic [LVL_W-1:0]       fifoCount;
  logic                   fifoPushValid, fifoPopReady;
  logic [15:0]            fifoPushData, fifoPopData;
  logic                   cardRdReq, cardRdAck, cardWrReq, cardWrAck;
  logic [7:0]             cardRdData, cardWrData;
  logic [CNT_W-1:0]       lenLive, cntLive;
  logic                   busy, doneStb;

  blk_xfer_ctr #(.LEN_FIELD_W(LEN_FIELD_W), .FIFO_DEPTH(FIFO_DEPTH)) dut (
    .clk(clk), .rstN(rstN),
    .lenWrEn(lenWrEn), .lenWrVal(lenWrVal), .cntWrEn(cntWrEn), .cntWrVal(cntWrVal),
    .startEn(startEn), .startDir(startDir), .afLevel(afLevel), .fifoCount(fifoCount),
    .fifoPushValid(fifoPushValid), .fifoPushData(fifoPushData),
    .fifoPopReady(fifoPopReady), .fifoPopData(fifoPopData),
    .cardRdReq(cardRdReq), .cardRdAck(cardRdAck), .cardRdData(cardRdData),
    .cardWrReq(cardWrReq), .cardWrAck(cardWrAck), .cardWrData(cardWrData),
    .lenLive(lenLive), .cntLive(cntLive), .busy(busy), .doneStb(doneStb)
  );

  // ---------------- environment models ----------------
  function automatic logic [7:0] rdByte(int k);
    return 8'(8'h41 + k);
  endfunction

  function automatic logic [15:0] wrWord(int h);
    return {8'(8'hA0 + h), 8'(8'h10 + h)};
  endfunction

  logic        mdlClr = 0, rdMode = 1, drainEn = 0, ackOn = 0, ackAll = 1;
  int          wrAvail = 0;
  int          head, tail, wrIdx, doneCnt;
  logic [7:0]  rdSeq;
  logic [15:0] pushLog [256];
  logic [7:0]  wrLog   [256];
  logic [7:0]  lfsr;

  assign fifoCount   = rdMode ? LVL_W'(tail - head) : LVL_W'(wrAvail - head);
  assign fifoPopData = wrWord(head);
  assign cardRdData  = rdSeq;
  assign cardRdAck   = ackOn && (ackAll || lfsr[0]);
  assign cardWrAck   = ackOn && (ackAll || lfsr[1]);

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) lfsr <= 8'hA5;
    else       lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always_ff @(posedge clk) begin
    if (mdlClr) begin
      head <= 0; tail <= 0; wrIdx <= 0; doneCnt <= 0; rdSeq <= 8'h41;
    end else begin
      if (fifoPushValid) begin
        pushLog[tail[7:0]] <= fifoPushData;
        tail <= tail + 1;
      end
      if (fifoPopReady || (drainEn && rdMode && (tail != head))) head <= head + 1;
      if (cardRdReq && cardRdAck) rdSeq <= rdSeq + 8'd1;
      if (cardWrReq && cardWrAck) begin
        wrLog[wrIdx[7:0]] <= cardWrData;
        wrIdx <= wrIdx + 1;
      end
      if (doneStb) doneCnt <= doneCnt + 1;
    end
  end

  // ---------------- checking helpers ----------------
  int nChecks = 0, nErr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLen(input int len);
    lenWrVal = LEN_FIELD_W'(len - 1); lenWrEn = 1; cyc(1); lenWrEn = 0;
  endtask

  task automatic setCnt(input int num);
    cntWrVal = LEN_FIELD_W'(num - 1); cntWrEn = 1; cyc(1); cntWrEn = 0;
  endtask

  task automatic clearModel(input logic dir, input int avail);
    rdMode = dir; wrAvail = avail; mdlClr = 1; cyc(1); mdlClr = 0;
  endtask

  task automatic startXfer(input logic dir);
    startDir = dir; startEn = 1; cyc(1); startEn = 0;
  endtask

  task automatic waitDone(input string tag);
    int t = 0;
    while (doneCnt == 0 && t < 3000) begin cyc(1); t++; end
    chk(doneCnt != 0, tag, doneCnt, 1);
    cyc(2);
  endtask

  // One full transfer with the FIFO never limiting, results checked arithmetically.
  task automatic runXfer(input logic dir, input int len, input int num, input logic all);
    int words = (len + 1) / 2;
    int bad = 0, firstAct = 0, firstExp = 0;
    setLen(len);
    chk(lenLive == CNT_W'(len), "R2 length load", int'(lenLive), len);
    setCnt(num);
    chk(cntLive == CNT_W'(num), "R3 count load", int'(cntLive), num);
    clearModel(dir, num * words);
    ackAll = all; ackOn = 1; drainEn = 1;
    startXfer(dir);
    waitDone("R9 transfer completes");
    chk(doneCnt == 1, "R9 single completion pulse", doneCnt, 1);
    chk(!busy && !cardRdReq && !cardWrReq, "R9 idle after end", int'(busy), 0);
    chk(lenLive == CNT_W'(len), "R9 byte counter reload", int'(lenLive), len);
    chk(cntLive == CNT_W'(num), "R9 block counter reload", int'(cntLive), num);
    if (dir) begin
      chk(tail == num * words, "R4 word count", tail, num * words);
      chk(rdSeq == rdByte(num * len), "R4 bytes requested", int'(rdSeq), int'(rdByte(num * len)));
      for (int b = 0; b < num; b++)
        for (int j = 0; j < words; j++) begin
          int k = b * len + 2 * j;
          logic [15:0] exp;
          exp = {(2 * j + 1 < len) ? rdByte(k + 1) : 8'h00, rdByte(k)};
          if (pushLog[b * words + j] != exp && bad++ == 0) begin
            firstAct = int'(pushLog[b * words + j]); firstExp = int'(exp);
          end
        end
      chk(bad == 0, "R4 word packing", firstAct, firstExp);
    end else begin
      int idx = 0;
      chk(head == num * words, "R5 words popped", head, num * words);
      chk(wrIdx == num * len, "R5 byte count", wrIdx, num * len);
      for (int b = 0; b < num; b++)
        for (int j = 0; j < words; j++) begin
          logic [15:0] w;
          w = wrWord(b * words + j);
          if (wrLog[idx] != w[7:0] && bad++ == 0) begin
            firstAct = int'(wrLog[idx]); firstExp = int'(w[7:0]);
          end
          idx++;
          if (2 * j + 1 < len) begin
            if (wrLog[idx] != w[15:8] && bad++ == 0) begin
              firstAct = int'(wrLog[idx]); firstExp = int'(w[15:8]);
            end
            idx++;
          end
        end
      chk(bad == 0, "R5 byte splitting", firstAct, firstExp);
    end
    ackOn = 0; drainEn = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    mdlClr = 1;
    cyc(3);
    rstN = 1;
    cyc(1);
    mdlClr = 0;
    cyc(1);

    // R1 reset state
    chk(lenLive == 0 && cntLive == 0, "R1 counters zero", int'(lenLive) + int'(cntLive), 0);
    chk(!busy && !doneStb, "R1 idle", int'(busy) + int'(doneStb), 0);
    chk(!cardRdReq && !cardWrReq && !fifoPushValid && !fifoPopReady, "R1 strobes low",
        int'(cardRdReq) + int'(cardWrReq) + int'(fifoPushValid) + int'(fifoPopReady), 0);

    // Sweep: both directions, lengths 1..9, counts 1..3, steady and gapped acks
    for (int d = 0; d < 2; d++)
      for (int len = 1; len <= 9; len++)
        for (int num = 1; num <= 3; num++)
          runXfer(d[0], len, num, (len % 2) == 0);

    // R6: read pauses above the almost-full threshold
    afLevel = LVL_W'(1);
    setLen(8); setCnt(1);
    clearModel(1'b1, 0);
    ackAll = 1; ackOn = 1; drainEn = 0;
    startXfer(1'b1);
    cyc(30);
    chk(tail == 2, "R6 words before pause", tail, 2);
    chk(!cardRdReq, "R6 read request held off", int'(cardRdReq), 0);
    chk(lenLive == CNT_W'(4), "R6 bytes before pause", int'(lenLive), 4);
    drainEn = 1;
    waitDone("R6 resumes after drain");
    chk(tail == 4, "R6 total words", tail, 4);
    ackOn = 0; drainEn = 0;
    afLevel = '1;

    // R7: write pauses while FIFO is empty
    setLen(6); setCnt(1);
    clearModel(1'b0, 1);
    ackAll = 1; ackOn = 1;
    startXfer(1'b0);
    cyc(30);
    chk(wrIdx == 2, "R7 bytes before pause", wrIdx, 2);
    chk(!cardWrReq, "R7 write request held off", int'(cardWrReq), 0);
    chk(lenLive == CNT_W'(4), "R7 live count at pause", int'(lenLive), 4);
    wrAvail = 3;
    waitDone("R7 resumes after refill");
    chk(wrIdx == 6, "R7 total bytes", wrIdx, 6);
    chk(wrLog[4] == wrWord(2)[7:0] && wrLog[5] == wrWord(2)[15:8], "R5 last word order",
        int'({wrLog[5], wrLog[4]}), int'(wrWord(2)));
    ackOn = 0;

    // R8, R10, R11, R3: byte-at-a-time read with rewrite of the count
    setLen(3); setCnt(2);
    clearModel(1'b1, 0);
    ackAll = 1; ackOn = 0; drainEn = 1;
    startXfer(1'b1);
    chk(cardRdReq && busy, "R6 read request when below threshold", int'(cardRdReq), 1);
    chk(lenLive == CNT_W'(3), "R11 no move without ack", int'(lenLive), 3);
    ackOn = 1; cyc(1); ackOn = 0;
    chk(lenLive == CNT_W'(2), "R11 one byte in one ack cycle", int'(lenLive), 2);
    chk(cntLive == CNT_W'(2), "R8 block counter mid-block", int'(cntLive), 2);
    startXfer(1'b0);
    chk(cardRdReq && !cardWrReq, "R10 start ignored while busy", int'(cardWrReq), 0);
    chk(lenLive == CNT_W'(2), "R11 req without ack holds", int'(lenLive), 2);
    setCnt(4);
    chk(cntLive == CNT_W'(4), "R3 count rewrite", int'(cntLive), 4);
    chk(lenLive == CNT_W'(3), "R3 byte counter reload", int'(lenLive), 3);
    ackOn = 1; cyc(3); ackOn = 0;
    chk(lenLive == CNT_W'(3), "R8 byte reload at boundary", int'(lenLive), 3);
    chk(cntLive == CNT_W'(3), "R8 block decrement", int'(cntLive), 3);
    chk(pushLog[0] == {rdByte(1), rdByte(0)}, "R4 first word", int'(pushLog[0]),
        int'({rdByte(1), rdByte(0)}));
    chk(pushLog[1] == {rdByte(3), rdByte(2)}, "R4 word after rewrite", int'(pushLog[1]),
        int'({rdByte(3), rdByte(2)}));
    ackOn = 1;
    waitDone("R9 long transfer completes");
    chk(tail == 8, "R4 words in long transfer", tail, 8);
    chk(pushLog[3] == {8'h00, rdByte(6)}, "R4 odd half-word", int'(pushLog[3]),
        int'({8'h00, rdByte(6)}));
    chk(cntLive == CNT_W'(4) && lenLive == CNT_W'(3), "R9 reload after rewrite",
        int'(cntLive), 4);
    ackOn = 0; drainEn = 0;

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule